// File: doc/BRIEF.md
# DRAM Bring-Up Sequencer

This block is a hardware state machine that takes a DRAM controller and its PHY from power-on reset to normal operation without boot firmware. It holds six reset domains, requests the memory clock, releases the resets in two stages around the register programming, and asks an external loader to stream each configuration group. It writes the PHY init-control word, waits a settle time, and polls PHY status. It then uses a mode-change handshake block for the quasi-dynamic updates: DFI-init-complete enable, refresh disable and refresh restore. Training runs next, and the two AXI ports are enabled last.

A pulse on `start` begins the sequence. The memory type (`mem_ddr3`) is captured at that moment. Each wait for an external condition is bounded by `TIMEOUT_CYC` cycles. A wait that runs out ends in a sticky error state with a cause code, and `boot_done` then never rises. The fixed delays (`APB_WAIT_CYC` after the controller APB reset is released, `SETTLE_CYC` after each PHY init-word write) are counted on one shared counter that clears on every state change.

Top module: `dram_boot_seq`

## Requirements
- R1: After reset, and in idle until `start`, all six bits of `dom_rst` are 1. `clk_req`, `grp_go`, `wr_en`, `hs_req`, `boot_done` and `boot_err` are all 0. The bit map of `dom_rst` is: 0 controller APB, 1 controller AXI, 2 controller core, 3 PHY APB, 4 PHY, 5 PHY control.
- R2: `start` raises `clk_req`. Once `clk_ok` is seen, bits 4 and 5 are released first (`dom_rst`=0x0F). One cycle later bit 0 is released (0x0E).
- R3: At least `APB_WAIT_CYC` cycles pass between the release of bit 0 and the first write or group request.
- R4: The order of requests is fixed. First a write to address 0 (DFI-init-complete enable) with data 0. Then groups 0 (static), 1 (timing) and 2 (address map). Then a write to address 1 (controller init mode) with data 0 (normal). Then group 3 (performance). Then bits 1, 2 and 3 are released (`dom_rst`=0). Then groups 4 (PHY static) and 5 (PHY timing) are requested. Each group gets a one-cycle `grp_go` and is waited on until `grp_done`.
- R5: The first PHY init word is written to address 2. It sets bit 0 (init), bit 1 (DLL soft reset), bit 2 (DLL lock), bit 3 (impedance calibration), bit 4 (ITM soft reset), bit 5 (DRAM init) and bit 7 (ICPC). It also sets bit 6 (DRAM reset) only for DDR3. The value is 0xBF, or 0xFF for DDR3.
- R6: No handshake follows a PHY init-word write until at least `SETTLE_CYC`+1 cycles have passed.
- R7: `phy_stat` bit 0 is init done and bits 1 to 5 are error flags. A poll ends on done or on any error flag. An error flag moves the block to the error state with cause 4, even if done is set in the same cycle.
- R8: After the first poll completes, handshake op 0 (set DFI-init-complete enable) runs. The block then waits for `ctl_normal`, and then runs handshake op 1 (refresh disable).
- R9: The training word is written to address 2. It is 0x101 (init plus DQS gate training) for DDR3, and 0x301 (read-valid training added) otherwise.
- R10: After the training poll, handshake op 2 (refresh restore) runs. Then address 3 and address 4 (AXI port 0 and port 1 enable) are each written with data 1. After that `boot_done` rises and stays high.
- R11: A wait that sees no completion within `TIMEOUT_CYC` cycles sets `boot_err` for good, and `boot_done` never rises. The cause code is 1 for the clock, 2 for the loader, 3 for a poll, 5 for a handshake and 6 for normal mode. A condition seen in the last allowed cycle wins over the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin bring-up (pulse) |
| mem_ddr3 | input | 1 | Memory type is DDR3, captured at start |
| dom_rst | output | 6 | Reset per domain, 1 = held in reset |
| clk_req | output | 1 | Memory clock enable request |
| clk_ok | input | 1 | Memory clock running and stable |
| grp_go | output | 1 | One-cycle request to stream a config group |
| grp_sel | output | 3 | Group number for `grp_go` |
| grp_done | input | 1 | Loader finished the requested group |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 3 | Write target code |
| wr_data | output | DATA_W | Write value |
| phy_stat | input | 6 | PHY status: bit 0 done, bits 1-5 errors |
| hs_req | output | 1 | Mode-change handshake request, held until ack |
| hs_op | output | 2 | Handshake operation code |
| hs_ack | input | 1 | Handshake complete |
| ctl_normal | input | 1 | Controller reports normal operating mode |
| boot_done | output | 1 | Bring-up complete (sticky) |
| boot_err | output | 1 | Bring-up failed (sticky) |
| err_cause | output | 3 | Failure cause code |

## Verification
Two decisions can meet in one cycle. The first is a wait's completion arriving on the very cycle the timeout counter reaches its last value. The bench delays `clk_ok` by exactly the limit minus one cycle and then by the limit. It expects a full boot in the first case and cause 1 in the second. The second collision is PHY status showing done together with an error flag. The bench injects that combined status and expects the error to win, with cause 4 and no `boot_done`.

// File: rtl/dram_boot_pkg.sv
package dram_boot_pkg;

  // reset domain bit positions in dom_rst
  localparam int RV_CTL_APB  = 0;
  localparam int RV_CTL_AXI  = 1;
  localparam int RV_CTL_CORE = 2;
  localparam int RV_PHY_APB  = 3;
  localparam int RV_PHY      = 4;
  localparam int RV_PHY_CTL  = 5;
  localparam int RV_N        = 6;

  // PHY init-control word bit positions
  localparam int W_INIT      = 0;
  localparam int W_DLL_SRST  = 1;
  localparam int W_DLL_LOCK  = 2;
  localparam int W_ZCAL      = 3;
  localparam int W_ITM_SRST  = 4;
  localparam int W_DRAM_INIT = 5;
  localparam int W_DRAM_RST  = 6;
  localparam int W_ICPC      = 7;
  localparam int W_GATE_TRN  = 8;
  localparam int W_RDV_TRN   = 9;

  // write target codes
  localparam logic [2:0] A_DFI_EN    = 3'd0;
  localparam logic [2:0] A_INIT_MODE = 3'd1;
  localparam logic [2:0] A_PHY_INIT  = 3'd2;
  localparam logic [2:0] A_PORT0     = 3'd3;
  localparam logic [2:0] A_PORT1     = 3'd4;

  // handshake operations
  localparam logic [1:0] H_DFI_ON   = 2'd0;
  localparam logic [1:0] H_RFSH_OFF = 2'd1;
  localparam logic [1:0] H_RESTORE  = 2'd2;

  // failure causes
  localparam logic [2:0] C_NONE  = 3'd0;
  localparam logic [2:0] C_CLK   = 3'd1;
  localparam logic [2:0] C_LOAD  = 3'd2;
  localparam logic [2:0] C_POLL  = 3'd3;
  localparam logic [2:0] C_PHYER = 3'd4;
  localparam logic [2:0] C_HS    = 3'd5;
  localparam logic [2:0] C_NORM  = 3'd6;

  // PHY status bits
  localparam int ST_DONE = 0;
  localparam int ST_N    = 6;

  typedef enum logic [4:0] {
    S_IDLE, S_CLK, S_REL_PHY, S_APB_WAIT, S_DFI_OFF,
    S_G_STATIC, S_G_TIMING, S_G_MAP, S_SKIP_WR, S_G_PERF,
    S_REL_CORE, S_G_PSTAT, S_G_PTIM, S_INIT_WR, S_SETTLE1,
    S_POLL1, S_HS_DFI, S_WAIT_NORM, S_HS_RFSH, S_TRAIN_WR,
    S_SETTLE2, S_POLL2, S_HS_REST, S_PORT0, S_PORT1,
    S_DONE, S_ERROR
  } seq_state_t;

endpackage

// File: rtl/dram_boot_timer.sv
module dram_boot_timer #(
  parameter int LIMIT = 1000,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  // cycles spent in the current state, saturating
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dram_boot_word.sv
module dram_boot_word
  import dram_boot_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              is_ddr3,
  input  logic              train,
  output logic [DATA_W-1:0] word
);
  always_comb begin
    word = '0;
    word[W_INIT] = 1'b1;
    if (train) begin
      word[W_GATE_TRN] = 1'b1;
      word[W_RDV_TRN]  = !is_ddr3;
    end else begin
      word[W_DLL_SRST]  = 1'b1;
      word[W_DLL_LOCK]  = 1'b1;
      word[W_ZCAL]      = 1'b1;
      word[W_ITM_SRST]  = 1'b1;
      word[W_DRAM_INIT] = 1'b1;
      word[W_ICPC]      = 1'b1;
      word[W_DRAM_RST]  = is_ddr3;
    end
  end
endmodule

// File: rtl/dram_boot_seq.sv
module dram_boot_seq
  import dram_boot_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int APB_WAIT_CYC = 128,
  parameter int SETTLE_CYC   = 10,
  parameter int TIMEOUT_CYC  = 1000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mem_ddr3,
  output logic [5:0]        dom_rst,
  output logic              clk_req,
  input  logic              clk_ok,
  output logic              grp_go,
  output logic [2:0]        grp_sel,
  input  logic              grp_done,
  output logic              wr_en,
  output logic [2:0]        wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic [5:0]        phy_stat,
  output logic              hs_req,
  output logic [1:0]        hs_op,
  input  logic              hs_ack,
  input  logic              ctl_normal,
  output logic              boot_done,
  output logic              boot_err,
  output logic [2:0]        err_cause
);
  localparam int CNT_MAX0 = (APB_WAIT_CYC > SETTLE_CYC) ? APB_WAIT_CYC : SETTLE_CYC;
  localparam int CNT_MAX  = (TIMEOUT_CYC > CNT_MAX0) ? TIMEOUT_CYC : CNT_MAX0;
  localparam int CW       = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] TO_LAST  = CW'(TIMEOUT_CYC - 1);
  localparam logic [CW-1:0] APB_LAST = CW'(APB_WAIT_CYC - 1);
  localparam logic [CW-1:0] SET_LAST = CW'(SETTLE_CYC - 1);

  seq_state_t state, state_n;
  logic [2:0] cause_q, cause_n;
  logic       type_q;
  logic [CW-1:0] cnt;
  logic       expired, phy_fault, phy_ok;
  logic [DATA_W-1:0] word;

  dram_boot_timer #(.LIMIT(CNT_MAX)) u_timer (
    .clk(clk), .rst(rst), .clr(state_n != state), .cnt(cnt)
  );

  dram_boot_word #(.DATA_W(DATA_W)) u_word (
    .is_ddr3(type_q), .train(state_n == S_TRAIN_WR), .word(word)
  );

  assign expired   = (cnt == TO_LAST);
  assign phy_fault = |phy_stat[ST_N-1:1];
  assign phy_ok    = phy_stat[ST_DONE];

  always_ff @(posedge clk) begin
    if (rst) type_q <= 1'b0;
    else if (state == S_IDLE && start) type_q <= mem_ddr3;
  end

  // next state
  always_comb begin
    state_n = state;
    cause_n = cause_q;
    case (state)
      S_IDLE:     if (start) state_n = S_CLK;
      S_CLK:      if (clk_ok) state_n = S_REL_PHY;
                  else if (expired) begin state_n = S_ERROR; cause_n = C_CLK; end
      S_REL_PHY:  state_n = S_APB_WAIT;
      S_APB_WAIT: if (cnt == APB_LAST) state_n = S_DFI_OFF;
      S_DFI_OFF:  state_n = S_G_STATIC;
      S_G_STATIC, S_G_TIMING, S_G_MAP, S_G_PERF, S_G_PSTAT, S_G_PTIM: begin
        if (grp_done) begin
          case (state)
            S_G_STATIC: state_n = S_G_TIMING;
            S_G_TIMING: state_n = S_G_MAP;
            S_G_MAP:    state_n = S_SKIP_WR;
            S_G_PERF:   state_n = S_REL_CORE;
            S_G_PSTAT:  state_n = S_G_PTIM;
            default:    state_n = S_INIT_WR;
          endcase
        end else if (expired) begin
          state_n = S_ERROR; cause_n = C_LOAD;
        end
      end
      S_SKIP_WR:  state_n = S_G_PERF;
      S_REL_CORE: state_n = S_G_PSTAT;
      S_INIT_WR:  state_n = S_SETTLE1;
      S_SETTLE1:  if (cnt == SET_LAST) state_n = S_POLL1;
      S_TRAIN_WR: state_n = S_SETTLE2;
      S_SETTLE2:  if (cnt == SET_LAST) state_n = S_POLL2;
      S_POLL1, S_POLL2: begin
        if (phy_fault) begin
          state_n = S_ERROR; cause_n = C_PHYER;
        end else if (phy_ok) begin
          state_n = (state == S_POLL1) ? S_HS_DFI : S_HS_REST;
        end else if (expired) begin
          state_n = S_ERROR; cause_n = C_POLL;
        end
      end
      S_HS_DFI, S_HS_RFSH, S_HS_REST: begin
        if (hs_ack) begin
          case (state)
            S_HS_DFI:  state_n = S_WAIT_NORM;
            S_HS_RFSH: state_n = S_TRAIN_WR;
            default:   state_n = S_PORT0;
          endcase
        end else if (expired) begin
          state_n = S_ERROR; cause_n = C_HS;
        end
      end
      S_WAIT_NORM: if (ctl_normal) state_n = S_HS_RFSH;
                   else if (expired) begin state_n = S_ERROR; cause_n = C_NORM; end
      S_PORT0:    state_n = S_PORT1;
      S_PORT1:    state_n = S_DONE;
      default:    state_n = state;
    endcase
  end

  // output decode of the next state, registered below
  logic [5:0]        rv_n;
  logic              clk_n, go_n, we_n, hr_n;
  logic [2:0]        sel_n, wa_n;
  logic [1:0]        ho_n;
  logic [DATA_W-1:0] wd_n;

  always_comb begin
    rv_n = '0;
    case (state_n)
      S_IDLE, S_CLK, S_ERROR: rv_n = '1;
      S_REL_PHY: begin
        rv_n = '1;
        rv_n[RV_PHY] = 1'b0;
        rv_n[RV_PHY_CTL] = 1'b0;
      end
      S_APB_WAIT, S_DFI_OFF, S_G_STATIC, S_G_TIMING, S_G_MAP, S_SKIP_WR, S_G_PERF: begin
        rv_n[RV_CTL_AXI]  = 1'b1;
        rv_n[RV_CTL_CORE] = 1'b1;
        rv_n[RV_PHY_APB]  = 1'b1;
      end
      default: rv_n = '0;
    endcase
  end

  always_comb begin
    clk_n = !(state_n == S_IDLE || state_n == S_ERROR);
    go_n  = 1'b0;
    sel_n = 3'd0;
    we_n  = 1'b0;
    wa_n  = 3'd0;
    wd_n  = '0;
    hr_n  = 1'b0;
    ho_n  = 2'd0;
    case (state_n)
      S_G_STATIC: begin go_n = 1'b1; sel_n = 3'd0; end
      S_G_TIMING: begin go_n = 1'b1; sel_n = 3'd1; end
      S_G_MAP:    begin go_n = 1'b1; sel_n = 3'd2; end
      S_G_PERF:   begin go_n = 1'b1; sel_n = 3'd3; end
      S_G_PSTAT:  begin go_n = 1'b1; sel_n = 3'd4; end
      S_G_PTIM:   begin go_n = 1'b1; sel_n = 3'd5; end
      S_DFI_OFF:  begin we_n = 1'b1; wa_n = A_DFI_EN; end
      S_SKIP_WR:  begin we_n = 1'b1; wa_n = A_INIT_MODE; end
      S_INIT_WR, S_TRAIN_WR: begin we_n = 1'b1; wa_n = A_PHY_INIT; wd_n = word; end
      S_PORT0:    begin we_n = 1'b1; wa_n = A_PORT0; wd_n = DATA_W'(1); end
      S_PORT1:    begin we_n = 1'b1; wa_n = A_PORT1; wd_n = DATA_W'(1); end
      S_HS_DFI:   begin hr_n = 1'b1; ho_n = H_DFI_ON; end
      S_HS_RFSH:  begin hr_n = 1'b1; ho_n = H_RFSH_OFF; end
      S_HS_REST:  begin hr_n = 1'b1; ho_n = H_RESTORE; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cause_q   <= C_NONE;
      dom_rst   <= '1;
      clk_req   <= 1'b0;
      grp_go    <= 1'b0;
      grp_sel   <= 3'd0;
      wr_en     <= 1'b0;
      wr_addr   <= 3'd0;
      wr_data   <= '0;
      hs_req    <= 1'b0;
      hs_op     <= 2'd0;
      boot_done <= 1'b0;
      boot_err  <= 1'b0;
      err_cause <= C_NONE;
    end else begin
      state     <= state_n;
      cause_q   <= cause_n;
      dom_rst   <= rv_n;
      clk_req   <= clk_n;
      grp_go    <= go_n && (state_n != state);
      grp_sel   <= sel_n;
      wr_en     <= we_n;
      wr_addr   <= wa_n;
      wr_data   <= wd_n;
      hs_req    <= hr_n;
      hs_op     <= ho_n;
      boot_done <= (state_n == S_DONE);
      boot_err  <= (state_n == S_ERROR);
      err_cause <= cause_n;
    end
  end
endmodule

// File: rtl/dram_boot_seq_chk.sv
module dram_boot_seq_chk
  import dram_boot_pkg::*;
#(
  parameter int APB_WAIT_CYC = 128,
  localparam int GW = $clog2(APB_WAIT_CYC + 2)
) (
  input logic       clk,
  input logic       rst,
  input logic [5:0] dom_rst,
  input logic       grp_go,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic       init_bit,
  input logic       boot_done,
  input logic       boot_err,
  input logic [2:0] err_cause
);
  localparam logic [GW-1:0] GTOP = GW'(APB_WAIT_CYC + 1);
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst || dom_rst[RV_CTL_APB]) gap <= '0;
    else if (gap != GTOP) gap <= gap + 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (dom_rst == 6'h3F && !boot_done && !boot_err && !grp_go && !wr_en));

  // R2
  phy_first_chk: assert property (@(posedge clk) disable iff (rst)
    !dom_rst[RV_CTL_APB] |-> (!dom_rst[RV_PHY] && !dom_rst[RV_PHY_CTL]));

  // R4
  core_after_apb_chk: assert property (@(posedge clk) disable iff (rst)
    !dom_rst[RV_CTL_CORE] |-> !dom_rst[RV_CTL_APB]);

  // R3
  apb_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (grp_go || wr_en) |-> (!dom_rst[RV_CTL_APB] && gap >= GW'(APB_WAIT_CYC)));

  // R4
  go_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    grp_go |=> !grp_go);

  // R5
  init_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_PHY_INIT) |-> init_bit);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    boot_err |=> (boot_err && $stable(err_cause)));

  // R11
  no_done_err_chk: assert property (@(posedge clk) disable iff (rst)
    !(boot_done && boot_err));

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    boot_done |=> boot_done);
endmodule

bind dram_boot_seq dram_boot_seq_chk #(.APB_WAIT_CYC(APB_WAIT_CYC)) u_chk (
  .clk(clk), .rst(rst), .dom_rst(dom_rst), .grp_go(grp_go), .wr_en(wr_en),
  .wr_addr(wr_addr), .init_bit(wr_data[dram_boot_pkg::W_INIT]),
  .boot_done(boot_done), .boot_err(boot_err), .err_cause(err_cause)
);

// File: tb/dram_boot_seq_test.sv
`timescale 1ns/100ps
module dram_boot_seq_test;
  localparam int TO = 40;
  localparam int SETTLE = 10;
  localparam int APBW = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic start = 1'b0, mem_ddr3 = 1'b0;
  logic [5:0] dom_rst;
  logic clk_req, clk_ok, grp_go, grp_done, wr_en, hs_req, hs_ack, ctl_normal;
  logic [2:0] grp_sel, wr_addr, err_cause;
  logic [31:0] wr_data;
  logic [5:0] phy_stat;
  logic [1:0] hs_op;
  logic boot_done, boot_err;

  dram_boot_seq #(.APB_WAIT_CYC(APBW), .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TO)) uut (
    .clk(clk), .rst(rst), .start(start), .mem_ddr3(mem_ddr3), .dom_rst(dom_rst),
    .clk_req(clk_req), .clk_ok(clk_ok), .grp_go(grp_go), .grp_sel(grp_sel),
    .grp_done(grp_done), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .phy_stat(phy_stat), .hs_req(hs_req), .hs_op(hs_op), .hs_ack(hs_ack),
    .ctl_normal(ctl_normal), .boot_done(boot_done), .boot_err(boot_err),
    .err_cause(err_cause)
  );

  int errs = 0, checks = 0, cyc = 0;
  int clk_lat = 3, load_lat = 4, phy_lat = 6, hs_lat = 3, norm_lat = 4;
  bit norm_en = 1'b1;
  logic [5:0] phy_val = 6'h01;

  // ---------------- environment models ----------------
  int ccnt, lcnt, pcnt, hcnt, ncnt;
  bit lbusy, pbusy, narm;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      clk_ok <= 1'b0; ccnt <= 0;
      grp_done <= 1'b0; lbusy <= 1'b0; lcnt <= 0;
      phy_stat <= '0; pbusy <= 1'b0; pcnt <= 0;
      hs_ack <= 1'b0; hcnt <= 0; narm <= 1'b0;
      ctl_normal <= 1'b0; ncnt <= 0;
    end else begin
      if (clk_req && !clk_ok) begin
        ccnt <= ccnt + 1;
        if (ccnt == clk_lat - 1) clk_ok <= 1'b1;
      end
      grp_done <= 1'b0;
      if (grp_go) begin lbusy <= 1'b1; lcnt <= 1; end
      else if (lbusy) begin
        if (lcnt == load_lat) begin grp_done <= 1'b1; lbusy <= 1'b0; end
        else lcnt <= lcnt + 1;
      end
      if (wr_en && wr_addr == 3'd2) begin phy_stat <= '0; pbusy <= 1'b1; pcnt <= 1; end
      else if (pbusy) begin
        if (pcnt == phy_lat) begin phy_stat <= phy_val; pbusy <= 1'b0; end
        else pcnt <= pcnt + 1;
      end
      hs_ack <= 1'b0;
      if (hs_req && !hs_ack) begin
        if (hcnt == hs_lat) begin
          hs_ack <= 1'b1; hcnt <= 0;
          if (hs_op == 2'd0) narm <= 1'b1;
        end else hcnt <= hcnt + 1;
      end
      if (narm && norm_en && !ctl_normal) begin
        ncnt <= ncnt + 1;
        if (ncnt == norm_lat) ctl_normal <= 1'b1;
      end
    end
  end

  // ---------------- event monitor ----------------
  int ev_k[64], ev_a[64], ev_c[64];
  logic [31:0] ev_d[64];
  int n_ev;
  logic [5:0] rv_prev;
  logic hs_prev;

  task automatic rec(input int k, input int a, input logic [31:0] d);
    if (n_ev < 64) begin
      ev_k[n_ev] = k; ev_a[n_ev] = a; ev_d[n_ev] = d; ev_c[n_ev] = cyc;
      n_ev = n_ev + 1;
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      n_ev = 0; rv_prev = dom_rst; hs_prev = 1'b0;
    end else begin
      if (dom_rst != rv_prev) rec(0, 0, {26'd0, dom_rst});
      if (grp_go) rec(1, int'(grp_sel), 32'd0);
      if (wr_en) rec(2, int'(wr_addr), wr_data);
      if (hs_req && !hs_prev) rec(3, int'(hs_op), 32'd0);
      rv_prev = dom_rst; hs_prev = hs_req;
    end
  end

  // ---------------- helpers ----------------
  int ex_k[64], ex_a[64];
  logic [31:0] ex_d[64];
  int n_ex;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int k, input int a, input logic [31:0] d);
    ex_k[n_ex] = k; ex_a[n_ex] = a; ex_d[n_ex] = d; n_ex++;
  endtask

  task automatic build_ok(input bit ddr3);
    n_ex = 0;
    push(0, 0, 32'h0F); push(0, 0, 32'h0E);
    push(2, 0, 32'h0);
    push(1, 0, 0); push(1, 1, 0); push(1, 2, 0);
    push(2, 1, 32'h0);
    push(1, 3, 0);
    push(0, 0, 32'h00);
    push(1, 4, 0); push(1, 5, 0);
    push(2, 2, ddr3 ? 32'hFF : 32'hBF);
    push(3, 0, 0); push(3, 1, 0);
    push(2, 2, ddr3 ? 32'h101 : 32'h301);
    push(3, 2, 0);
    push(2, 3, 32'h1); push(2, 4, 32'h1);
  endtask

  task automatic cmp_seq(input string req);
    int bad = 0;
    chk(n_ev == n_ex, req, "event count", n_ev, n_ex);
    for (int i = 0; i < n_ex && i < n_ev; i++)
      if (ev_k[i] != ex_k[i] || ev_a[i] != ex_a[i] || ev_d[i] != ex_d[i]) begin
        if (bad == 0)
          $display("  event %0d: kind %0d code %0d data 0x%0h, wanted kind %0d code %0d data 0x%0h",
                   i, ev_k[i], ev_a[i], ev_d[i], ex_k[i], ex_a[i], ex_d[i]);
        bad++;
      end
    chk(bad == 0, req, "event order mismatches", bad, 0);
  endtask

  task automatic defaults();
    clk_lat = 3; load_lat = 4; phy_lat = 6; hs_lat = 3; norm_lat = 4;
    norm_en = 1'b1; phy_val = 6'h01;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_boot(input bit ddr3);
    int guard = 0;
    do_reset();
    mem_ddr3 = ddr3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!(boot_done || boot_err) && guard < 4000) begin
      @(negedge clk); guard++;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    defaults();
    do_reset();
    chk(dom_rst == 6'h3F, "R1", "resets after reset", dom_rst, 6'h3F);
    chk(!clk_req && !grp_go && !wr_en && !hs_req, "R1", "strobes after reset",
        {clk_req, grp_go, wr_en, hs_req}, 0);
    repeat (10) @(negedge clk);
    chk(dom_rst == 6'h3F && !clk_req, "R1", "idle hold without start", dom_rst, 6'h3F);
    chk(!boot_done && !boot_err, "R1", "done/err idle", {boot_done, boot_err}, 0);
  endtask

  task automatic t_boot(input bit ddr3);
    defaults();
    run_boot(ddr3);
    build_ok(ddr3);
    cmp_seq(ddr3 ? "R4 ddr3" : "R4");
    chk(boot_done && !boot_err, "R10", "done after full boot", {boot_done, boot_err}, 2);
    chk(ev_c[1] - ev_c[0] == 1, "R2", "PHY release one cycle before APB",
        ev_c[1] - ev_c[0], 1);
    chk(ev_c[2] - ev_c[1] >= APBW, "R3", "APB wait cycles", ev_c[2] - ev_c[1], APBW);
    chk(ev_c[12] - ev_c[11] >= SETTLE + 1, "R6", "settle after init word",
        ev_c[12] - ev_c[11], SETTLE + 1);
    chk(ev_d[11] == (ddr3 ? 32'hFF : 32'hBF), "R5", "first init word",
        ev_d[11], ddr3 ? 32'hFF : 32'hBF);
    chk(ev_d[14] == (ddr3 ? 32'h101 : 32'h301), "R9", "training word",
        ev_d[14], ddr3 ? 32'h101 : 32'h301);
    chk(ev_k[12] == 3 && ev_a[12] == 0 && ev_k[13] == 3 && ev_a[13] == 1,
        "R8", "DFI-on then refresh-off handshakes", ev_a[13], 1);
    repeat (20) @(negedge clk);
    chk(boot_done, "R10", "done stays high", boot_done, 1);
  endtask

  task automatic t_phy_err();
    defaults();
    phy_val = 6'h09;  // done together with an error flag
    run_boot(1'b0);
    chk(boot_err && !boot_done, "R7", "error wins over done", {boot_err, boot_done}, 2);
    chk(err_cause == 3'd4, "R7", "cause for PHY error", err_cause, 4);
    chk(n_ev == 12, "R7", "nothing after init word", n_ev, 12);
  endtask

  task automatic t_poll_timeout();
    defaults();
    phy_val = 6'h00;
    run_boot(1'b0);
    chk(boot_err && err_cause == 3'd3, "R11", "poll timeout cause", err_cause, 3);
  endtask

  task automatic t_clk_edge();
    defaults();
    clk_lat = TO - 1;
    run_boot(1'b0);
    chk(boot_done && !boot_err, "R11", "clock in last allowed cycle", boot_done, 1);
    defaults();
    clk_lat = TO;
    run_boot(1'b0);
    chk(boot_err && err_cause == 3'd1, "R11", "clock one cycle late", err_cause, 1);
    chk(!boot_done && n_ev == 0, "R11", "no progress after clock timeout", n_ev, 0);
  endtask

  task automatic t_load_timeout();
    defaults();
    load_lat = 100;
    run_boot(1'b1);
    chk(boot_err && err_cause == 3'd2, "R11", "loader timeout cause", err_cause, 2);
    repeat (30) @(negedge clk);
    chk(boot_err && !boot_done && err_cause == 3'd2, "R11", "error sticky", err_cause, 2);
    chk(dom_rst == 6'h3F, "R11", "resets reasserted in error", dom_rst, 6'h3F);
  endtask

  task automatic t_norm_timeout();
    defaults();
    norm_en = 1'b0;
    run_boot(1'b0);
    chk(boot_err && err_cause == 3'd6, "R8", "normal-mode wait timeout", err_cause, 6);
    chk(n_ev == 13, "R8", "no refresh-off before normal", n_ev, 13);
  endtask

  initial begin
    t_reset();
    t_boot(1'b0);
    t_boot(1'b1);
    t_phy_err();
    t_poll_timeout();
    t_clk_edge();
    t_load_timeout();
    t_norm_timeout();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule